// File: doc/BRIEF.md
# Programmable Condition Comparator Array

This block turns a packet's context into a row of condition bits for a stateful packet-processing pipeline. With each valid packet it receives the values of that packet's per-flow registers, a bank of global registers shared by every flow, and a set of header fields that have already been parsed. A fixed number of comparator slots each choose two 32-bit operands from these sources, or from a constant held in the slot's own configuration. Each slot then applies one relational operator to the pair. The slot results are collected into a condition vector, one bit per slot. A downstream wildcard match stage consumes that vector.

The block does no arithmetic on the operands. A condition that depends on a sum or any other derived quantity must compare a register that an earlier packet's update already wrote. Configuration is loaded through a small write-only register port. Each slot has two 32-bit words: a control word (enable, two operand selectors, operator) and an immediate constant. New configuration takes effect for the packet presented in the cycle after the write.

Top module: `cond_cmp_array`

## Requirements
- R1: While rst_n is low and after reset is released, out_valid and every cond_vec bit are 0, and every slot is disabled until it is configured.
- R2: out_valid equals in_valid of the previous cycle. cond_vec is loaded only in a cycle with in_valid high and holds its value otherwise.
- R3: Operand selector codes map as follows: 0..3 choose flow register 0..3, 4..7 choose global register 0..3, 8..11 choose header field 0..3, and 12 chooses the slot's immediate constant. Codes 13..15 yield the operand value 0. Register k sits at bits [32k+31:32k] of its bus.
- R4: Operator codes compare A with B as unsigned 32-bit values: 0 is A>B, 1 is A<B, 2 is A==B, 3 is A<=B, 4 is A>=B.
- R5: Operator codes 5, 6 and 7 make the slot's bit 0 whatever the operands are.
- R6: A slot whose enable bit is 0 drives its cond_vec bit to 0.
- R7: A write with cfg_we high targets slot cfg_addr[3:1]. With cfg_addr[0]=0 it loads the control word: enable = bit 0, selector A = bits [4:1], selector B = bits [8:5], operator = bits [11:9]; bits [31:12] are ignored. With cfg_addr[0]=1 it loads the 32-bit immediate.
- R8: A packet presented in the same cycle as a configuration write is evaluated with the configuration in force before that write. The write applies from the next cycle on.
- R9: The comparisons are unsigned, so 0xFFFFFFFF is greater than 0x00000001 and 0x80000000 is greater than 0x7FFFFFFF.
- R10: Bit i of cond_vec depends only on slot i's configuration. A write to one slot leaves the results of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Slot index [3:1] and word select [0] |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Packet context valid |
| flow_regs | input | 128 | Four per-flow register values |
| glob_regs | input | 128 | Four global register values |
| hdr_fields | input | 128 | Four packet header field values |
| out_valid | output | 1 | Condition vector valid |
| cond_vec | output | 8 | One condition bit per slot |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the same cycle as a packet whose result depends on the slot being rewritten. The packet must see the old configuration while the next packet sees the new one. The stimulus produces this on purpose by pairing writes with valid packets, and it also repeats it many times in a random phase where writes and packets overlap freely. Operand values are drawn from a small pool that includes 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. This makes equal operands and sign-bit boundaries frequent, so every operator sees its equal, greater and lesser cases.

// File: rtl/cca_pkg.sv
package cca_pkg;

    // Relational operator encoding; codes above OP_GE are reserved.
    typedef enum logic [2:0] {
        OP_GT = 3'd0,
        OP_LT = 3'd1,
        OP_EQ = 3'd2,
        OP_LE = 3'd3,
        OP_GE = 3'd4
    } relop_e;

    localparam int unsigned OP_W = 3;

    // Number of selector bits needed for three register classes plus an immediate.
    function automatic int unsigned sel_width(input int unsigned regs_per_class);
        return $clog2(3 * regs_per_class + 1);
    endfunction

endpackage

// File: rtl/cca_operand_mux.sv
module cca_operand_mux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REGS   = 4,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [SEL_W-1:0]       sel,
    input  logic [REGS*DATA_W-1:0] flow_bus,
    input  logic [REGS*DATA_W-1:0] glob_bus,
    input  logic [REGS*DATA_W-1:0] hdr_bus,
    input  logic [DATA_W-1:0]      imm,
    output logic [DATA_W-1:0]      opnd
);
    localparam int GLOB_BASE = int'(REGS);
    localparam int HDR_BASE  = 2 * int'(REGS);
    localparam int IMM_CODE  = 3 * int'(REGS);

    always_comb begin
        int code;
        code = int'(sel);
        opnd = '0;
        if (code < GLOB_BASE) begin
            opnd = flow_bus[code*DATA_W +: DATA_W];
        end else if (code < HDR_BASE) begin
            opnd = glob_bus[(code-GLOB_BASE)*DATA_W +: DATA_W];
        end else if (code < IMM_CODE) begin
            opnd = hdr_bus[(code-HDR_BASE)*DATA_W +: DATA_W];
        end else if (code == IMM_CODE) begin
            opnd = imm;
        end
    end
endmodule

// File: rtl/cca_relop.sv
module cca_relop
    import cca_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              en,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              hit
);
    always_comb begin
        logic raw;
        case (op)
            OP_GT:   raw = (a >  b);
            OP_LT:   raw = (a <  b);
            OP_EQ:   raw = (a == b);
            OP_LE:   raw = (a <= b);
            OP_GE:   raw = (a >= b);
            default: raw = 1'b0;
        endcase
        hit = en & raw;
    end
endmodule

// File: rtl/cca_slot.sv
module cca_slot
    import cca_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REGS   = 4,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                   en,
    input  logic [SEL_W-1:0]       sel_a,
    input  logic [SEL_W-1:0]       sel_b,
    input  logic [OP_W-1:0]        op,
    input  logic [DATA_W-1:0]      imm,
    input  logic [REGS*DATA_W-1:0] flow_bus,
    input  logic [REGS*DATA_W-1:0] glob_bus,
    input  logic [REGS*DATA_W-1:0] hdr_bus,
    output logic                   hit
);
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;

    cca_operand_mux #(.DATA_W(DATA_W), .REGS(REGS), .SEL_W(SEL_W)) u_mux_a (
        .sel(sel_a), .flow_bus(flow_bus), .glob_bus(glob_bus),
        .hdr_bus(hdr_bus), .imm(imm), .opnd(opnd_a)
    );

    cca_operand_mux #(.DATA_W(DATA_W), .REGS(REGS), .SEL_W(SEL_W)) u_mux_b (
        .sel(sel_b), .flow_bus(flow_bus), .glob_bus(glob_bus),
        .hdr_bus(hdr_bus), .imm(imm), .opnd(opnd_b)
    );

    cca_relop #(.DATA_W(DATA_W)) u_relop (
        .en(en), .op(op), .a(opnd_a), .b(opnd_b), .hit(hit)
    );
endmodule

// File: rtl/cond_cmp_array.sv
module cond_cmp_array
    import cca_pkg::*;
#(
    parameter int unsigned NUM_CMP = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned REGS    = 4,
    parameter int unsigned ADDR_W  = $clog2(NUM_CMP) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    input  logic                   in_valid,
    input  logic [REGS*DATA_W-1:0] flow_regs,
    input  logic [REGS*DATA_W-1:0] glob_regs,
    input  logic [REGS*DATA_W-1:0] hdr_fields,
    output logic                   out_valid,
    output logic [NUM_CMP-1:0]     cond_vec
);
    localparam int unsigned SEL_W   = sel_width(REGS);
    localparam int unsigned SA_LO   = 1;
    localparam int unsigned SB_LO   = SA_LO + SEL_W;
    localparam int unsigned OP_LO   = SB_LO + SEL_W;
    localparam int unsigned IDX_W   = ADDR_W - 1;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  sel_a;
        logic [SEL_W-1:0]  sel_b;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] imm;
    } slot_cfg_t;

    typedef struct packed {
        slot_cfg_t [NUM_CMP-1:0] cfg;
        logic [NUM_CMP-1:0]      cond;
        logic                    vld;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NUM_CMP-1:0] hit_vec;
    logic [NUM_CMP-1:0] en_vec;
    logic [NUM_CMP-1:0] rsvd_vec;

    for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_slot
        cca_slot #(.DATA_W(DATA_W), .REGS(REGS), .SEL_W(SEL_W)) u_slot (
            .en       (state_q.cfg[gi].en),
            .sel_a    (state_q.cfg[gi].sel_a),
            .sel_b    (state_q.cfg[gi].sel_b),
            .op       (state_q.cfg[gi].op),
            .imm      (state_q.cfg[gi].imm),
            .flow_bus (flow_regs),
            .glob_bus (glob_regs),
            .hdr_bus  (hdr_fields),
            .hit      (hit_vec[gi])
        );
        assign en_vec[gi]   = state_q.cfg[gi].en;
        assign rsvd_vec[gi] = (state_q.cfg[gi].op > OP_W'(OP_GE));
    end

    always_comb begin
        logic [IDX_W-1:0] widx;
        state_d = state_q;
        widx    = cfg_addr[ADDR_W-1:1];

        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.cond = hit_vec;
        end

        if (cfg_we && (int'(widx) < int'(NUM_CMP))) begin
            if (cfg_addr[0]) begin
                state_d.cfg[widx].imm = cfg_wdata;
            end else begin
                state_d.cfg[widx].en    = cfg_wdata[0];
                state_d.cfg[widx].sel_a = cfg_wdata[SA_LO +: SEL_W];
                state_d.cfg[widx].sel_b = cfg_wdata[SB_LO +: SEL_W];
                state_d.cfg[widx].op    = cfg_wdata[OP_LO +: OP_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign cond_vec  = state_q.cond;
endmodule

// File: rtl/cca_checker.sv
module cca_checker #(
    parameter int unsigned NUM_CMP = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [NUM_CMP-1:0] cond_vec,
    input logic [NUM_CMP-1:0] en_vec,
    input logic [NUM_CMP-1:0] rsvd_vec
);
    // R2: output valid trails input valid by exactly one cycle
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2: without a packet the condition vector is frozen
    assert_cond_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(cond_vec));

    for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_slot_chk
        // R6: a disabled slot never reports a hit
        assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && !$past(en_vec[gi])) |-> !cond_vec[gi]);

        // R5: reserved operator codes never report a hit
        assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && $past(rsvd_vec[gi])) |-> !cond_vec[gi]);
    end
endmodule

bind cond_cmp_array cca_checker #(.NUM_CMP(NUM_CMP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .cond_vec  (cond_vec),
    .en_vec    (en_vec),
    .rsvd_vec  (rsvd_vec)
);

// File: tb/cond_cmp_array_tb.sv
module cond_cmp_array_tb;
    localparam int NC = 8;
    localparam int DW = 32;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          in_valid = 1'b0;
    logic [127:0]  flow_regs = '0;
    logic [127:0]  glob_regs = '0;
    logic [127:0]  hdr_fields = '0;
    logic          out_valid;
    logic [NC-1:0] cond_vec;

    always #4 clk = ~clk;  // 125 MHz

    cond_cmp_array u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .flow_regs(flow_regs),
        .glob_regs(glob_regs), .hdr_fields(hdr_fields),
        .out_valid(out_valid), .cond_vec(cond_vec)
    );

    // Behavioural reference state
    int      m_en [NC];
    int      m_sa [NC];
    int      m_sb [NC];
    int      m_op [NC];
    logic [31:0] m_imm [NC];
    logic        exp_vld;
    logic [NC-1:0] exp_cond;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 6))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'(($urandom_range(0, 3)));
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [31:0] ref_opnd(int code, int s);
        if (code < 4)  return flow_regs[code*32 +: 32];
        if (code < 8)  return glob_regs[(code-4)*32 +: 32];
        if (code < 12) return hdr_fields[(code-8)*32 +: 32];
        if (code == 12) return m_imm[s];
        return 32'h0;
    endfunction

    function automatic bit ref_rel(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            0: return a > b;
            1: return a < b;
            2: return a == b;
            3: return a <= b;
            4: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    // Reference model: evaluate with pre-write configuration, then apply the write
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_vld  = 1'b0;
            exp_cond = '0;
            for (int s = 0; s < NC; s++) begin
                m_en[s] = 0; m_sa[s] = 0; m_sb[s] = 0; m_op[s] = 0; m_imm[s] = '0;
            end
        end else begin
            exp_vld = in_valid;
            if (in_valid) begin
                for (int s = 0; s < NC; s++) begin
                    exp_cond[s] = (m_en[s] != 0) &&
                        ref_rel(m_op[s], ref_opnd(m_sa[s], s), ref_opnd(m_sb[s], s));
                end
            end
            if (cfg_we) begin
                if (cfg_addr[0]) begin
                    m_imm[cfg_addr[3:1]] = cfg_wdata;
                end else begin
                    m_en[cfg_addr[3:1]] = int'(cfg_wdata[0]);
                    m_sa[cfg_addr[3:1]] = int'(cfg_wdata[4:1]);
                    m_sb[cfg_addr[3:1]] = int'(cfg_wdata[8:5]);
                    m_op[cfg_addr[3:1]] = int'(cfg_wdata[11:9]);
                end
            end
        end
    end

    task automatic compare();
        n_cmp++;
        if (out_valid !== exp_vld || cond_vec !== exp_cond) begin
            n_bad++;
            $display("FAIL %s: out_valid=%b cond_vec=%b expected out_valid=%b cond_vec=%b",
                     tag, out_valid, cond_vec, exp_vld, exp_cond);
        end
    endtask

    task automatic step(input bit v, input bit we, input logic [3:0] addr,
                        input logic [31:0] data);
        @(negedge clk);
        compare();
        in_valid  = v;
        cfg_we    = we;
        cfg_addr  = addr;
        cfg_wdata = data;
        for (int k = 0; k < NR; k++) begin
            flow_regs[k*32 +: 32]  = pick_val();
            glob_regs[k*32 +: 32]  = pick_val();
            hdr_fields[k*32 +: 32] = pick_val();
        end
    endtask

    // R7: junk in bits [31:12] must be ignored
    task automatic wr_ctrl(input int s, input bit en, input int sa, input int sb,
                           input int op, input bit v);
        step(v, 1'b1, {3'(s), 1'b0},
             {20'($urandom), 3'(op), 4'(sb), 4'(sa), en});
    endtask

    task automatic wr_imm(input int s, input logic [31:0] val, input bit v);
        step(v, 1'b1, {3'(s), 1'b1}, val);
    endtask

    task automatic pkts(input int n);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, '0, '0);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) begin @(negedge clk); compare(); end
        rst_n = 1'b1;
        pkts(4);

        // R7: program every slot, immediates included
        tag = "R7";
        for (int s = 0; s < NC; s++) begin
            wr_imm(s, pick_val(), 1'b0);
            wr_ctrl(s, 1'b1, s, 12, s % 5, 1'b0);
        end
        pkts(6);

        // R3: every selector code for A against the immediate
        tag = "R3";
        for (int c = 0; c < 16; c++) begin
            for (int s = 0; s < NC; s++) wr_ctrl(s, 1'b1, c, 12, 2 + (s % 3), 1'b0);
            pkts(8);
        end

        // R4: each operator across varied operand pairs
        tag = "R4";
        for (int op = 0; op < 5; op++) begin
            for (int s = 0; s < NC; s++) wr_ctrl(s, 1'b1, s, 11 - s, op, 1'b0);
            pkts(12);
        end

        // R5: reserved operator codes
        tag = "R5";
        for (int s = 0; s < NC; s++) wr_ctrl(s, 1'b1, 0, 4, 5 + (s % 3), 1'b0);
        pkts(10);

        // R6: disabled slots with otherwise-true settings
        tag = "R6";
        for (int s = 0; s < NC; s++) wr_ctrl(s, s[0], 12, 12, 2, 1'b0);
        pkts(6);

        // R9: unsigned boundary against immediate
        tag = "R9";
        wr_imm(0, 32'h0000_0001, 1'b0);
        wr_ctrl(0, 1'b1, 12, 0, 0, 1'b0);
        step(1'b0, 1'b0, '0, '0);
        in_valid = 1'b1; flow_regs[31:0] = 32'hFFFF_FFFF;
        @(negedge clk); compare();
        flow_regs[31:0] = 32'h8000_0000; wr_imm(0, 32'h7FFF_FFFF, 1'b0);
        @(negedge clk); compare();
        in_valid = 1'b1; flow_regs[31:0] = 32'h7FFF_FFFF; wr_ctrl(0, 1'b1, 0, 12, 0, 1'b1);
        pkts(4);

        // R8: writes coinciding with packets
        tag = "R8";
        for (int k = 0; k < 40; k++) begin
            wr_ctrl(k % NC, 1'b1, $urandom_range(0, 15), $urandom_range(0, 15),
                    $urandom_range(0, 4), 1'b1);
            wr_imm(k % NC, pick_val(), 1'b1);
        end
        pkts(3);

        // R2: idle gaps must hold the vector
        tag = "R2";
        for (int k = 0; k < 60; k++) step(k % 3 == 0, 1'b0, '0, '0);

        // R10: free mix of writes and packets across slots
        tag = "R10";
        for (int k = 0; k < 3000; k++) begin
            step($urandom_range(0, 1), $urandom_range(0, 3) == 0,
                 4'($urandom), $urandom);
        end
        step(1'b0, 1'b0, '0, '0);
        step(1'b0, 1'b0, '0, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL %s: watchdog expired, actual=hung expected=finished", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule